// File: doc/BRIEF.md
# Integer Execute Unit with Stored Carry and Condition Field

This block is the integer execute stage for operations that a decoder has already broken into fields. Each issue cycle it takes an opcode, several candidate operand sources, and a set of control flags. It produces a 64-bit result with a write request for the destination register. It can also update a persistent carry flag and a three-bit condition field that records the sign of the result.

Operand selection is fixed-priority. The first operand comes from read port 1 if that port is valid, otherwise from read port 3, and is zero when neither is valid. The second operand is the immediate if it is valid, otherwise read port 2, and is zero when neither is valid. The first operand may be complemented before use. The carry into an add is zero, one, or the carry stored by an earlier operation.

All outputs are registered. The result, the write request and the illegal-operation flag appear in the cycle after the issue edge and last one cycle. The stored carry and the condition field hold their values until a legal issue updates them.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0 (add) produces operand1 + operand2 + carry-in, truncated to 64 bits.
- R2: Opcode 1 produces the bitwise AND of the operands. Opcode 2 produces the bitwise OR.
- R3: Opcode 3 produces the low 64 bits of the product of the two operands.
- R4: When `inv_a` is set, operand 1 is replaced by its 64-bit complement before the operation.
- R5: Carry-in select: `cin_sel` 0 gives zero, 1 gives one, 2 gives the stored carry, and 3 gives zero.
- R6: On a legal issue with `cout_en` set, bit 64 of the full-width result becomes the stored carry. For AND and OR this bit is zero; for multiply it is product bit 64. With `cout_en` clear, the stored carry is held.
- R7: On a legal issue with `rec` set, `cond` becomes 3'b001 if the 64-bit result is zero, 3'b100 if result bit 63 is set, and 3'b010 otherwise. With `rec` clear, `cond` is held.
- R8: Operand 1 is taken from port 1 if `src1_ok` is set, else from port 3 if `src3_ok` is set, else it is zero. Operand 2 is the immediate if `imm_ok` is set, else port 2 if `src2_ok` is set, else it is zero.
- R9: Opcodes 4 to 7 raise `illegal` for one cycle and cause no register write, no carry update and no condition update.
- R10: After reset, `carry`, `cond`, `res_we` and `illegal` are zero. `carry` and `cond` do not change in a cycle without `issue`.
- R11: `res_we` is high in the cycle after an issue edge only when the opcode is legal and `dst_ok` was set. A cleared `dst_ok` does not block the carry or condition update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Operation valid this cycle |
| opc | input | 3 | Opcode: 0 add, 1 and, 2 or, 3 multiply |
| src1_ok | input | 1 | Read port 1 valid |
| src1_val | input | 64 | Read port 1 data |
| src3_ok | input | 1 | Read port 3 valid |
| src3_val | input | 64 | Read port 3 data |
| src2_ok | input | 1 | Read port 2 valid |
| src2_val | input | 64 | Read port 2 data |
| imm_ok | input | 1 | Immediate valid |
| imm_val | input | 64 | Immediate data |
| inv_a | input | 1 | Complement operand 1 |
| cin_sel | input | 2 | Carry-in source |
| cout_en | input | 1 | Store carry-out |
| rec | input | 1 | Update condition field |
| dst_ok | input | 1 | Destination register requested |
| res | output | 64 | Registered result |
| res_we | output | 1 | Result write enable |
| illegal | output | 1 | Unsupported opcode flag |
| cond | output | 3 | Condition field: negative, positive, zero |
| carry | output | 1 | Stored carry |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any issue. They also assume that the control inputs are stable across each rising edge. The driver changes every input only on the falling edge and asserts reset for several cycles at the start, so both assumptions hold. Idle cycles are driven with `rec` and `cout_en` raised so that the hold checks have something they could wrongly react to.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [2:0]   opc,
  input  logic         src1_ok,
  input  logic [W-1:0] src1_val,
  input  logic         src3_ok,
  input  logic [W-1:0] src3_val,
  input  logic         src2_ok,
  input  logic [W-1:0] src2_val,
  input  logic         imm_ok,
  input  logic [W-1:0] imm_val,
  input  logic         inv_a,
  input  logic [1:0]   cin_sel,
  input  logic         cout_en,
  input  logic         rec,
  input  logic         dst_ok,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic         illegal,
  output logic [2:0]   cond,
  output logic         carry
);
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_AND = 3'd1;
  localparam logic [2:0] OP_OR  = 3'd2;
  localparam logic [2:0] OP_MUL = 3'd3;

  logic [W-1:0]   a_pick, a_in, b_in;
  logic           cin;
  logic [W:0]     wide;
  logic [2*W-1:0] prod;
  logic           legal;
  logic [2:0]     cond_nxt;

  assign a_pick = src1_ok ? src1_val : (src3_ok ? src3_val : '0);
  assign a_in   = inv_a ? ~a_pick : a_pick;
  assign b_in   = imm_ok ? imm_val : (src2_ok ? src2_val : '0);
  assign prod   = {{W{1'b0}}, a_in} * {{W{1'b0}}, b_in};
  assign legal  = (opc <= OP_MUL);

  always_comb begin
    case (cin_sel)
      2'd1:    cin = 1'b1;
      2'd2:    cin = carry;
      default: cin = 1'b0;
    endcase
  end

  always_comb begin
    case (opc)
      OP_ADD:  wide = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, cin};
      OP_AND:  wide = {1'b0, a_in & b_in};
      OP_OR:   wide = {1'b0, a_in | b_in};
      OP_MUL:  wide = prod[W:0];
      default: wide = '0;
    endcase
  end

  assign cond_nxt = (wide[W-1:0] == '0) ? 3'b001 :
                    (wide[W-1]         ? 3'b100 : 3'b010);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res     <= '0;
      res_we  <= 1'b0;
      illegal <= 1'b0;
      cond    <= 3'b000;
      carry   <= 1'b0;
    end else begin
      res_we  <= issue && legal && dst_ok;
      illegal <= issue && !legal;
      if (issue && legal) begin
        res <= wide[W-1:0];
        if (cout_en) carry <= wide[W];
        if (rec)     cond  <= cond_nxt;
      end
    end
  end

  AST_WE_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> !illegal); // R9
  AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(carry) && $stable(cond) && !res_we && !illegal); // R10
  AST_ILLEGAL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opc > OP_MUL) |=> illegal && !res_we && $stable(carry) && $stable(cond)); // R9
  AST_NO_DST_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !dst_ok) |=> !res_we); // R11
  AST_NO_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !rec) |=> $stable(cond)); // R7
  AST_NO_COUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !cout_en) |=> $stable(carry)); // R6
endmodule

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [2:0] opc = '0;
  logic src1_ok = 1'b0, src3_ok = 1'b0, src2_ok = 1'b0, imm_ok = 1'b0;
  logic [63:0] src1_val = '0, src3_val = '0, src2_val = '0, imm_val = '0;
  logic inv_a = 1'b0, cout_en = 1'b0, rec = 1'b0, dst_ok = 1'b0;
  logic [1:0] cin_sel = '0;
  logic [63:0] res;
  logic res_we, illegal, carry;
  logic [2:0] cond;

  always #5 clk = ~clk;

  int_exec_unit #(.W(64)) dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opc(opc),
    .src1_ok(src1_ok), .src1_val(src1_val), .src3_ok(src3_ok), .src3_val(src3_val),
    .src2_ok(src2_ok), .src2_val(src2_val), .imm_ok(imm_ok), .imm_val(imm_val),
    .inv_a(inv_a), .cin_sel(cin_sel), .cout_en(cout_en), .rec(rec), .dst_ok(dst_ok),
    .res(res), .res_we(res_we), .illegal(illegal), .cond(cond), .carry(carry)
  );

  typedef struct {
    logic [63:0] res;
    logic        we;
    logic        ill;
    logic [2:0]  cond;
    logic        carry;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  logic       m_carry = 1'b0;
  logic [2:0] m_cond  = 3'b000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit iss, input logic [2:0] op,
                      input bit s1ok, input logic [63:0] s1, input bit s3ok, input logic [63:0] s3,
                      input bit s2ok, input logic [63:0] s2, input bit iok, input logic [63:0] im,
                      input bit inv, input logic [1:0] cs, input bit ce, input bit rc, input bit dst,
                      input string tag);
    logic [63:0] a, b;
    logic [127:0] full;
    logic ci;
    exp_t e;
    @(negedge clk);
    issue = iss; opc = op; src1_ok = s1ok; src1_val = s1; src3_ok = s3ok; src3_val = s3;
    src2_ok = s2ok; src2_val = s2; imm_ok = iok; imm_val = im; inv_a = inv; cin_sel = cs;
    cout_en = ce; rec = rc; dst_ok = dst;
    a = s1ok ? s1 : (s3ok ? s3 : 64'd0);
    if (inv) a = a ^ ONES;
    b = iok ? im : (s2ok ? s2 : 64'd0);
    ci = (cs == 2'd1) ? 1'b1 : ((cs == 2'd2) ? m_carry : 1'b0);
    case (op)
      3'd0: full = {64'd0, a} + {64'd0, b} + {127'd0, ci};
      3'd1: full = {64'd0, a & b};
      3'd2: full = {64'd0, a | b};
      3'd3: full = {64'd0, a} * {64'd0, b};
      default: full = '0;
    endcase
    e.res = full[63:0];
    e.we  = iss && (op < 3'd4) && dst;
    e.ill = iss && (op >= 3'd4);
    if (iss && op < 3'd4) begin
      if (ce) m_carry = full[64];
      if (rc) m_cond = (full[63:0] == 64'd0) ? 3'b001 : (full[63] ? 3'b100 : 3'b010);
    end
    e.cond = m_cond; e.carry = m_carry; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "res_we", {63'd0, res_we}, {63'd0, e.we});
      check(e.tag, "illegal", {63'd0, illegal}, {63'd0, e.ill});
      check(e.tag, "cond", {61'd0, cond}, {61'd0, e.cond});
      check(e.tag, "carry", {63'd0, carry}, {63'd0, e.carry});
      if (e.we) check(e.tag, "res", res, e.res);
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check("R10", "reset res_we", {63'd0, res_we}, 64'd0);
    check("R10", "reset cond", {61'd0, cond}, 64'd0);
    check("R10", "reset carry", {63'd0, carry}, 64'd0);
    rst_n = 1'b1;
    // R1 plain add, R7 positive
    step(1, 3'd0, 1, 64'd5, 0, 0, 1, 64'd7, 0, 0, 0, 2'd0, 0, 1, 1, "R1");
    // R6 R7 carry out and zero result
    step(1, 3'd0, 1, ONES, 0, 0, 1, 64'd1, 0, 0, 0, 2'd0, 1, 1, 1, "R6");
    // R5 stored carry in
    step(1, 3'd0, 1, 64'd2, 0, 0, 1, 64'd3, 0, 0, 0, 2'd2, 0, 0, 1, "R5");
    // R5 constant one
    step(1, 3'd0, 1, 64'd10, 0, 0, 1, 64'd20, 0, 0, 0, 2'd1, 0, 0, 1, "R5");
    // R5 select 3 acts as zero
    step(1, 3'd0, 1, 64'd10, 0, 0, 1, 64'd20, 0, 0, 0, 2'd3, 0, 0, 1, "R5");
    // R6 carry-out disabled holds carry
    step(1, 3'd0, 1, ONES, 0, 0, 1, ONES, 0, 0, 0, 2'd0, 0, 0, 1, "R6");
    // R2 AND, OR, with carry clear from AND
    step(1, 3'd1, 1, 64'hF0F0_1234_5678_FFFF, 0, 0, 1, 64'h0FF0_FFFF_0000_00F0, 0, 0, 0, 2'd0, 1, 1, 1, "R2");
    step(1, 3'd2, 1, 64'h8000_0000_0000_0001, 0, 0, 1, 64'h0000_0000_0000_0100, 0, 0, 0, 2'd0, 0, 1, 1, "R2");
    // R3 multiply
    step(1, 3'd3, 1, 64'd3, 0, 0, 1, 64'd5, 0, 0, 0, 2'd0, 1, 1, 1, "R3");
    step(1, 3'd3, 1, 64'h1_0000_0000, 0, 0, 1, 64'h1_0000_0000, 0, 0, 0, 2'd0, 1, 1, 1, "R3");
    step(1, 3'd3, 1, 64'h1234_5678_9ABC_DEF1, 0, 0, 1, 64'hFEDC_BA98_7654_3211, 0, 0, 0, 2'd0, 0, 1, 1, "R3");
    // R4 invert operand 1
    step(1, 3'd0, 1, 64'd0, 0, 0, 1, 64'd0, 0, 0, 1, 2'd0, 1, 1, 1, "R4");
    step(1, 3'd0, 1, 64'd6, 0, 0, 1, 64'd6, 0, 0, 1, 2'd1, 1, 1, 1, "R4");
    // R8 priorities
    step(1, 3'd2, 1, 64'h11, 1, 64'h2200, 1, 64'h4, 0, 0, 0, 2'd0, 0, 0, 1, "R8");
    step(1, 3'd2, 0, 64'h11, 1, 64'h2200, 1, 64'h4, 1, 64'h8000, 0, 2'd0, 0, 0, 1, "R8");
    step(1, 3'd2, 0, 64'h11, 0, 64'h2200, 0, 64'h4, 0, 64'h8000, 0, 2'd0, 0, 1, 1, "R8");
    // set a known carry and cond before illegal tests
    step(1, 3'd0, 1, ONES, 0, 0, 1, 64'd2, 0, 0, 0, 2'd0, 1, 1, 1, "R6");
    // R9 illegal opcodes
    step(1, 3'd5, 1, 64'd0, 0, 0, 1, 64'd0, 0, 0, 0, 2'd0, 1, 1, 1, "R9");
    step(1, 3'd7, 1, ONES, 0, 0, 1, 64'd1, 0, 0, 0, 2'd0, 1, 1, 1, "R9");
    // R10 idle cycles with flags raised
    step(0, 3'd0, 1, 64'd0, 0, 0, 1, 64'd0, 0, 0, 0, 2'd0, 1, 1, 1, "R10");
    step(0, 3'd3, 1, ONES, 0, 0, 1, ONES, 0, 0, 1, 2'd1, 1, 1, 1, "R10");
    // R11 no destination: no write, carry and cond still update
    step(1, 3'd0, 1, 64'h8000_0000_0000_0000, 0, 0, 1, 64'h8000_0000_0000_0000, 0, 0, 0, 2'd0, 1, 1, 0, "R11");
    step(1, 3'd0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 1, 64'd0, 0, 0, 0, 2'd0, 1, 1, 0, "R11");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule